// File: doc/BRIEF.md
# Cascaded Interrupt Funnel with Per-Line Polarity

This block gathers a group of peripheral interrupt lines and presents them to a parent interrupt controller as one active-high level. Each line is first brought into the local clock domain through two flops. A per-line polarity bit then selects whether the line is active high or active low. A global mode bit chooses whether activity is captured as a level or as a rising edge of the corrected signal. Captured activity sets sticky status bits, and software clears them by writing ones to a clear register.

An enable mask decides which status bits reach the output. The mask gates only the output, so masked lines still latch status and software can poll them. A global enable bit in the control register stops all new latching while it is low. Software reaches the block through a plain register port with address, write data, write strobe, read strobe and combinational read data.

Top module: `irq_funnel`

## Requirements
- R1: The 32-bit registers sit at these byte addresses: control 0x00, enable 0x04, status 0x08 (read-only), clear 0x0C (write-only, reads 0) and polarity 0x10.
- R2: While control bit 31 is 0, no status bit goes from 0 to 1.
- R3: If control bit 30 is 1, a status bit is set only by a rising edge of the polarity-corrected line. If it is 0, the bit is set in every cycle the corrected line is active.
- R4: A polarity bit of 1 makes its line active high. A polarity bit of 0 makes it active low.
- R5: Writing the clear register clears every status bit whose write-data bit is 1, across all 18 status bits. Status bits whose write-data bit is 0 are left unchanged.
- R6: In level mode, a status bit cleared while its line is still active reads 0 for the cycle after the clearing write and is set again on the following clock.
- R7: `irq_out` is high exactly when the bitwise AND of enable and status is nonzero.
- R8: After reset, control, enable, status and polarity all read 0 and `irq_out` is low.
- R9: A line whose enable bit is 0 still latches its status bit.
- R10: Reads at unmapped addresses return 0. Enable and polarity bits above line 15, status bits above bit 17 and control bits 29 to 0 read as 0. Read data is 0 while `rd_en` is low.
- R11: A change on an input line reaches the status register on the third rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 5 | Byte address of the register access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Combinational read data |
| irq_in | input | 16 | Peripheral interrupt lines, asynchronous |
| irq_out | output | 1 | Active-high level to the parent controller |

## Verification
The bench builds the block with its defaults: sixteen lines and an 18-bit status field. With these values every routed line can be driven and the two unrouted status bits can be observed only as bits that read 0 and that a clear write covers. The three-edge input latency and the one-cycle gap after a clear in level mode are checked on exact cycles. Polarity inversion and edge capture are also checked on lines that stay active across a clear.

// File: rtl/irq_funnel.sv
module irq_funnel #(
  parameter int LINES  = 16,
  parameter int STAT_W = 18,
  parameter int AW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic [31:0]       wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [31:0]       rdata,
  input  logic [LINES-1:0]  irq_in,
  output logic              irq_out
);
  localparam logic [AW-1:0] A_CTRL = AW'(5'h00);
  localparam logic [AW-1:0] A_ENA  = AW'(5'h04);
  localparam logic [AW-1:0] A_STAT = AW'(5'h08);
  localparam logic [AW-1:0] A_CLR  = AW'(5'h0C);
  localparam logic [AW-1:0] A_POL  = AW'(5'h10);

  logic              ctrl_en, ctrl_edge;
  logic [LINES-1:0]  enable, polarity;
  logic [STAT_W-1:0] status, status_set, clr_mask;
  logic [LINES-1:0]  sync1, sync2, act, act_d, rise;
  logic              unused_bits;

  assign unused_bits = ^{wdata[29:STAT_W]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      act_d <= '0;
    end else begin
      sync1 <= irq_in;
      sync2 <= sync1;
      act_d <= act;
    end

  assign act  = sync2 ~^ polarity;
  assign rise = act & ~act_d;

  always_comb begin
    status_set = '0;
    if (ctrl_en) status_set[LINES-1:0] = ctrl_edge ? rise : act;
  end

  assign clr_mask = (wr_en && addr == A_CLR) ? wdata[STAT_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      ctrl_edge <= 1'b0;
      enable    <= '0;
      polarity  <= '0;
      status    <= '0;
    end else begin
      if (wr_en && addr == A_CTRL) begin
        ctrl_en   <= wdata[31];
        ctrl_edge <= wdata[30];
      end
      if (wr_en && addr == A_ENA) enable   <= wdata[LINES-1:0];
      if (wr_en && addr == A_POL) polarity <= wdata[LINES-1:0];
      status <= (status | status_set) & ~clr_mask;
    end

  always_comb begin
    rdata = '0;
    if (rd_en)
      case (addr)
        A_CTRL: rdata = {ctrl_en, ctrl_edge, 30'd0};
        A_ENA:  rdata[LINES-1:0]  = enable;
        A_STAT: rdata[STAT_W-1:0] = status;
        A_POL:  rdata[LINES-1:0]  = polarity;
        default: rdata = '0;
      endcase
  end

  assign irq_out = |(enable & status[LINES-1:0]);

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> ((status & ~$past(status)) == '0)); // R2
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CLR) |=> ((status & $past(wdata[STAT_W-1:0])) == '0)); // R5
  AST_OUT_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (enable != '0)); // R7
  AST_STAT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_STAT) |-> (rdata[31:STAT_W] == '0)); // R10
endmodule

// File: tb/sim_irq_funnel.sv
module sim_irq_funnel;
  logic        clk = 0, rst_n = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        wr_en = 0, rd_en = 0, irq_out;
  logic [15:0] irq_in = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  irq_funnel u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
                 .rd_en(rd_en), .rdata(rdata), .irq_in(irq_in), .irq_out(irq_out));

  always #4 clk = ~clk;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    addr = a; rd_en = 1; #1 d = rdata; rd_en = 0;
  endtask

  task automatic drive(logic [15:0] v);
    @(negedge clk); irq_in = v;
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(5'h00, d); chk("R8 ctrl", d, 0);
    rd(5'h04, d); chk("R8 enable", d, 0);
    rd(5'h08, d); chk("R8 status", d, 0);
    rd(5'h10, d); chk("R8 polarity", d, 0);
    chk("R8 irq_out", irq_out, 0);
  endtask

  task automatic t_map;
    logic [31:0] d;
    wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, d); chk("R10 enable upper", d, 32'h0000_FFFF);
    wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, d); chk("R1 polarity", d, 32'h0000_FFFF);
    wr(5'h00, 32'h3FFF_FFFF); rd(5'h00, d); chk("R10 ctrl low bits", d, 0);
    rd(5'h14, d); chk("R10 unmapped", d, 0);
    rd(5'h0C, d); chk("R1 clear reads 0", d, 0);
    addr = 5'h04; #1 chk("R10 no rd_en", rdata, 0);
    wr(5'h04, 0);
  endtask

  task automatic t_disabled;
    logic [31:0] d;
    drive(16'h0005); wait_clk(5);
    rd(5'h08, d); chk("R2 no latch while off", d, 0);
  endtask

  task automatic t_latency;
    logic [31:0] d;
    wr(5'h00, 32'h8000_0000);
    wait_clk(1);
    rd(5'h08, d); chk("R3 level capture", d, 32'h5);
    drive(0); wr(5'h0C, 32'h3FFFF); wait_clk(3);
    rd(5'h08, d); chk("R5 all clear", d, 0);
    drive(16'h0010);
    @(posedge clk); @(posedge clk); #1;
    rd(5'h08, d); chk("R11 not yet after two edges", d, 0);
    @(posedge clk); #1;
    rd(5'h08, d); chk("R11 set on third edge", d, 32'h10);
    chk("R9 masked line latched, out low", {d[4], irq_out}, 2'b10);
  endtask

  task automatic t_reset_level;
    logic [31:0] d;
    wr(5'h0C, 32'h10);
    rd(5'h08, d); chk("R6 cleared cycle", d, 0);
    @(posedge clk); #1;
    rd(5'h08, d); chk("R6 set again", d, 32'h10);
  endtask

  task automatic t_output;
    wr(5'h04, 32'h4); #1 chk("R7 mask miss", irq_out, 0);
    wr(5'h04, 32'h10); #1 chk("R7 mask hit", irq_out, 1);
    drive(0); wr(5'h0C, 32'h10); #1 chk("R7 after clear", irq_out, 0);
  endtask

  task automatic t_polarity;
    logic [31:0] d;
    wr(5'h10, 32'hFEFF); wr(5'h0C, 32'h3FFFF); wait_clk(1);
    rd(5'h08, d); chk("R4 active-low line idle", d, 32'h100);
    drive(16'h0100); wait_clk(3); wr(5'h0C, 32'h3FFFF); wait_clk(1);
    rd(5'h08, d); chk("R4 active-low line driven high", d, 0);
    wr(5'h10, 32'hFFFF);
  endtask

  task automatic t_edge;
    logic [31:0] d;
    drive(0); wr(5'h00, 32'hC000_0000); wait_clk(3); wr(5'h0C, 32'h3FFFF);
    drive(16'h0008); wait_clk(4);
    rd(5'h08, d); chk("R3 edge sets", d, 32'h8);
    wr(5'h0C, 32'h8); wait_clk(3);
    rd(5'h08, d); chk("R3 held level no re-set", d, 0);
    drive(16'h0000); wait_clk(3);
    drive(16'h0008); wait_clk(4);
    rd(5'h08, d); chk("R3 second edge sets", d, 32'h8);
  endtask

  task automatic t_clear_sel;
    logic [31:0] d;
    wr(5'h00, 32'h8000_0000); drive(16'h0003); wait_clk(3);
    wr(5'h00, 0); drive(0); wait_clk(3);
    wr(5'h0C, 0); rd(5'h08, d); chk("R5 zero write keeps", d, 32'hB);
    wr(5'h0C, 32'h2); rd(5'h08, d); chk("R5 single bit", d, 32'h9);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #20 rst_n = 1;
    @(negedge clk);
    t_reset;
    t_map;
    t_disabled;
    t_latency;
    t_reset_level;
    t_output;
    t_polarity;
    t_edge;
    t_clear_sel;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule